// File: doc/BRIEF.md
# Parallel Multi-Exponential Pulse Shaper

This block turns a stream of per-clock hit amplitudes into a detector-like waveform that a 16-bit converter running several times faster than the logic clock can play out. Each clock it produces `LANES` consecutive samples. Three first-order recursive filters run side by side. A fast-decay and a slow-decay filter make the tail. A third filter is subtracted from their sum, so the pulse starts from zero at the hit sample and then rises. The recursion of each filter is rewritten so that its feedback spans a whole clock (`LANES` samples), which keeps the loop to one register.

A hit is presented as a valid flag, an unsigned amplitude and a lane index that places its onset inside the clock's group of samples. Software-held coefficient ports supply the powers of each filter's pole and the injection weights. The summed waveform is scaled by a gain and clamped to the signed 16-bit range, with a flag raised when clamping occurred.

Top module: `pulse_shaper`

## Requirements
- R1: While `rst_n` is low, every sample of `dac_word` is 0 and `clip` is 0.
- R2: A hit presented before clock edge t changes `dac_word` after edge t+1 and not earlier. Sample k of a clock is the 16-bit field `dac_word[16k+15:16k]`, and k=0 is the earliest in time.
- R3: When every filter state is zero and a hit arrives on lane L (`hit_lane` read as a binary index), the samples 0..L of that clock are exactly 0.
- R4: Each filter obeys y[n] = a*y[n-1] + x[n]. Its port holds a^m, for m from 1 to LANES, in bits [18(m-1)+17 : 18(m-1)], as unsigned Q1.17 (1.0 = 131072). The fast filter is driven by x = amp*w_fast and the slow filter by x = amp*w_slow, with both weights in Q1.17. The rise filter is driven by the sum of the two. Each sample is floor((fast + slow - rise) * gain / 256).
- R5: When `hit_valid` is low, `hit_amp` and `hit_lane` have no effect on any output.
- R6: A scaled sample above 32767 is output as 32767 and one below -32768 as -32768. `clip` is 1 for exactly the clocks whose word holds a clamped sample.
- R7: The gain applied to a word is the `gain` value present at the edge that loads that word. A gain of 0 gives an all-zero word with `clip` low.
- R8: Hits on successive clocks superpose linearly, and the recursion carries across clock boundaries without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_valid | input | 1 | A hit is present this clock |
| hit_amp | input | AMP_W | Unsigned hit amplitude |
| hit_lane | input | SEL_W | Sample lane of the hit onset |
| w_fast | input | 18 | Fast-tail injection weight, Q1.17 |
| w_slow | input | 18 | Slow-tail injection weight, Q1.17 |
| pow_rise | input | LANES*18 | Pole powers a^1..a^LANES of the rise filter |
| pow_fast | input | LANES*18 | Pole powers of the fast filter |
| pow_slow | input | LANES*18 | Pole powers of the slow filter |
| gain | input | GAIN_W | Output gain, 8 fraction bits |
| dac_word | output | LANES*OUT_W | LANES signed samples, earliest in the low field |
| clip | output | 1 | Some sample of this word was clamped |

## Verification
The bench builds the block with its defaults: eight lanes, 16-bit amplitude, gain and output, and a three-bit lane index. This reaches every onset position within a clock, and it carries the feedback across a full eight-sample look-ahead span. A serial, sample-by-sample real-valued model of the three recursions supplies the expected words, so the look-ahead rewrite is compared against the plain recursion rather than against itself. Gains up to 255.996 drive the clamp to both rails, and a swapped pole set makes the rise outlast the tails so that the sum goes negative.

// File: rtl/pshape_pkg.sv
package pshape_pkg;
    localparam int ST_W      = 32;
    localparam int COEF_W    = 18;
    localparam int COEF_FRAC = 17;
    localparam int NCOMP     = 3;

    typedef enum logic [1:0] {
        COMP_RISE = 2'd0,
        COMP_FAST = 2'd1,
        COMP_SLOW = 2'd2
    } comp_e;

    localparam logic signed [63:0] ST_MAX = (64'sd1 <<< (ST_W - 1)) - 64'sd1;
    localparam logic signed [63:0] ST_MIN = -(64'sd1 <<< (ST_W - 1));

    // Clamp a wide intermediate to the filter state range.
    function automatic logic signed [ST_W-1:0] sat_state(input logic signed [63:0] v);
        logic signed [ST_W-1:0] r;
        if (v > ST_MAX)      r = ST_MAX[ST_W-1:0];
        else if (v < ST_MIN) r = ST_MIN[ST_W-1:0];
        else                 r = v[ST_W-1:0];
        return r;
    endfunction

    // Sign-extend a state-width value to the wide working width.
    function automatic logic signed [63:0] widen(input logic signed [ST_W-1:0] y);
        return {{(64 - ST_W){y[ST_W-1]}}, y};
    endfunction

    // Signed state times unsigned Q1.17 coefficient, floored back to integer.
    function automatic logic signed [63:0] coef_mul(input logic signed [ST_W-1:0] y,
                                                    input logic [COEF_W-1:0] c);
        logic signed [63:0] ye;
        logic signed [63:0] ce;
        logic signed [63:0] p;
        ye = widen(y);
        ce = {{(64 - COEF_W){1'b0}}, c};
        p  = ye * ce;
        return p >>> COEF_FRAC;
    endfunction
endpackage

// File: rtl/pshape_inject.sv
module pshape_inject
    import pshape_pkg::*;
#(
    parameter int AMP_W = 16
) (
    input  logic                   hit_valid,
    input  logic [AMP_W-1:0]       hit_amp,
    input  logic [COEF_W-1:0]      w_fast,
    input  logic [COEF_W-1:0]      w_slow,
    output logic signed [ST_W-1:0] x_rise,
    output logic signed [ST_W-1:0] x_fast,
    output logic signed [ST_W-1:0] x_slow
);
    logic signed [ST_W-1:0] amp_s;

    always_comb begin
        amp_s = '0;
        if (hit_valid) amp_s = {{(ST_W - AMP_W){1'b0}}, hit_amp};
        x_fast = sat_state(coef_mul(amp_s, w_fast));
        x_slow = sat_state(coef_mul(amp_s, w_slow));
        // The rise term carries both tails so the sum starts at zero.
        x_rise = sat_state(widen(x_fast) + widen(x_slow));
    end
endmodule

// File: rtl/pshape_pole.sv
module pshape_pole
    import pshape_pkg::*;
#(
    parameter int LANES = 8,
    parameter int SEL_W = 3,
    localparam int POW_W  = LANES * COEF_W,
    localparam int LANE_W = LANES * ST_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [ST_W-1:0] x_in,
    input  logic [SEL_W-1:0]       onset_sel,
    input  logic [POW_W-1:0]       pow_tab,
    output logic [LANE_W-1:0]      lane_y,
    output logic signed [ST_W-1:0] state_y
);
    typedef struct packed {
        logic signed [ST_W-1:0] carry;
    } pole_st_t;

    pole_st_t cur_q;
    pole_st_t cur_d;

    // Look-ahead form: sample k of this clock depends only on the last
    // sample of the previous clock, scaled by a^(k+1), plus the injected
    // hit scaled by a^(k - onset).
    always_comb begin
        lane_y = '0;
        cur_d  = cur_q;
        for (int k = 0; k < LANES; k++) begin
            logic signed [63:0]     acc;
            logic signed [ST_W-1:0] v;
            int                     gap;
            acc = coef_mul(cur_q.carry, pow_tab[k*COEF_W +: COEF_W]);
            gap = k - int'(onset_sel);
            if (gap == 0) begin
                acc = acc + widen(x_in);
            end else if (gap > 0) begin
                acc = acc + coef_mul(x_in, pow_tab[(gap-1)*COEF_W +: COEF_W]);
            end
            v = sat_state(acc);
            lane_y[k*ST_W +: ST_W] = v;
            if (k == LANES - 1) cur_d.carry = v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign state_y = cur_q.carry;
endmodule

// File: rtl/pshape_out.sv
module pshape_out
    import pshape_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int SUM_W     = 34,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 8,
    parameter int OUT_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES*SUM_W-1:0]   sum_in,
    input  logic [GAIN_W-1:0]        gain,
    output logic [LANES*OUT_W-1:0]   word,
    output logic                     clip
);
    localparam logic signed [63:0] O_MAX = (64'sd1 <<< (OUT_W - 1)) - 64'sd1;
    localparam logic signed [63:0] O_MIN = -(64'sd1 <<< (OUT_W - 1));

    typedef struct packed {
        logic [LANES*OUT_W-1:0] word;
        logic                   clip;
    } out_st_t;

    out_st_t out_q;
    out_st_t out_d;

    always_comb begin
        out_d = out_q;
        out_d.clip = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            logic signed [SUM_W-1:0] sl;
            logic signed [63:0]      s;
            logic signed [63:0]      g;
            logic signed [63:0]      p;
            sl = sum_in[k*SUM_W +: SUM_W];
            s  = {{(64 - SUM_W){sl[SUM_W-1]}}, sl};
            g  = {{(64 - GAIN_W){1'b0}}, gain};
            p  = (s * g) >>> GAIN_FRAC;
            if (p > O_MAX) begin
                p = O_MAX;
                out_d.clip = 1'b1;
            end else if (p < O_MIN) begin
                p = O_MIN;
                out_d.clip = 1'b1;
            end
            out_d.word[k*OUT_W +: OUT_W] = p[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign word = out_q.word;
    assign clip = out_q.clip;
endmodule

// File: rtl/pulse_shaper.sv
module pulse_shaper
    import pshape_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int AMP_W     = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 8,
    parameter int OUT_W     = 16,
    localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int SUM_W  = ST_W + 2,
    localparam int POW_W  = LANES * COEF_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hit_valid,
    input  logic [AMP_W-1:0]       hit_amp,
    input  logic [SEL_W-1:0]       hit_lane,
    input  logic [COEF_W-1:0]      w_fast,
    input  logic [COEF_W-1:0]      w_slow,
    input  logic [POW_W-1:0]       pow_rise,
    input  logic [POW_W-1:0]       pow_fast,
    input  logic [POW_W-1:0]       pow_slow,
    input  logic [GAIN_W-1:0]      gain,
    output logic [LANES*OUT_W-1:0] dac_word,
    output logic                   clip
);
    localparam int LANE_W = LANES * ST_W;

    logic signed [ST_W-1:0]     x_rise;
    logic signed [ST_W-1:0]     x_fast;
    logic signed [ST_W-1:0]     x_slow;
    logic [NCOMP*LANE_W-1:0]    comp_lanes;
    logic [NCOMP*ST_W-1:0]      comp_state;
    logic [LANES*SUM_W-1:0]     sum_lanes_q;

    pshape_inject #(.AMP_W(AMP_W)) u_inject (
        .hit_valid (hit_valid),
        .hit_amp   (hit_amp),
        .w_fast    (w_fast),
        .w_slow    (w_slow),
        .x_rise    (x_rise),
        .x_fast    (x_fast),
        .x_slow    (x_slow)
    );

    for (genvar c = 0; c < NCOMP; c++) begin : g_comp
        logic signed [ST_W-1:0] x_sel;
        logic [POW_W-1:0]       pow_sel;
        if (c == int'(COMP_RISE)) begin : g_rise
            assign x_sel   = x_rise;
            assign pow_sel = pow_rise;
        end else if (c == int'(COMP_FAST)) begin : g_fast
            assign x_sel   = x_fast;
            assign pow_sel = pow_fast;
        end else begin : g_slow
            assign x_sel   = x_slow;
            assign pow_sel = pow_slow;
        end

        pshape_pole #(.LANES(LANES), .SEL_W(SEL_W)) u_pole (
            .clk       (clk),
            .rst_n     (rst_n),
            .x_in      (x_sel),
            .onset_sel (hit_lane),
            .pow_tab   (pow_sel),
            .lane_y    (comp_lanes[c*LANE_W +: LANE_W]),
            .state_y   (comp_state[c*ST_W +: ST_W])
        );
    end

    typedef struct packed {
        logic [LANES*SUM_W-1:0] lanes;
    } sum_st_t;

    sum_st_t sum_q;
    sum_st_t sum_d;

    // Combine tails minus rise per lane; the width has two guard bits
    // so no saturation is needed here.
    always_comb begin
        sum_d = sum_q;
        for (int k = 0; k < LANES; k++) begin
            logic signed [ST_W-1:0]  r;
            logic signed [ST_W-1:0]  f;
            logic signed [ST_W-1:0]  s;
            logic signed [SUM_W-1:0] t;
            r = comp_lanes[int'(COMP_RISE)*LANE_W + k*ST_W +: ST_W];
            f = comp_lanes[int'(COMP_FAST)*LANE_W + k*ST_W +: ST_W];
            s = comp_lanes[int'(COMP_SLOW)*LANE_W + k*ST_W +: ST_W];
            t = SUM_W'(f) + SUM_W'(s) - SUM_W'(r);
            sum_d.lanes[k*SUM_W +: SUM_W] = t;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum_lanes_q = sum_q.lanes;

    pshape_out #(
        .LANES     (LANES),
        .SUM_W     (SUM_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC),
        .OUT_W     (OUT_W)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .sum_in (sum_lanes_q),
        .gain   (gain),
        .word   (dac_word),
        .clip   (clip)
    );
endmodule

// File: rtl/pulse_shaper_chk.sv
module pulse_shaper_chk #(
    parameter int LANES  = 8,
    parameter int SEL_W  = 3,
    parameter int SUM_W  = 34,
    parameter int OUT_W  = 16,
    parameter int GAIN_W = 16,
    parameter int ST_TOT = 96
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   hit_valid,
    input logic [SEL_W-1:0]       hit_lane,
    input logic [GAIN_W-1:0]      gain,
    input logic [LANES*OUT_W-1:0] dac_word,
    input logic                   clip,
    input logic [ST_TOT-1:0]      comp_state,
    input logic [LANES*SUM_W-1:0] sum_lanes_q
);
    logic [SEL_W-1:0] lane_r;
    logic             st_zero;
    logic             onset_ok;
    logic             rail_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_r <= '0;
        else        lane_r <= hit_lane;
    end

    always_comb begin
        st_zero  = (comp_state == '0);
        onset_ok = 1'b1;
        rail_hit = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (k <= int'(lane_r) && sum_lanes_q[k*SUM_W +: SUM_W] != '0) onset_ok = 1'b0;
            if (dac_word[k*OUT_W +: OUT_W] == {1'b0, {(OUT_W-1){1'b1}}} ||
                dac_word[k*OUT_W +: OUT_W] == {1'b1, {(OUT_W-1){1'b0}}}) rail_hit = 1'b1;
        end
    end

    p_onset_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && st_zero) |=> onset_ok);

    p_idle_stays_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_zero && !hit_valid) |=> st_zero);

    p_clip_on_rail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clip |-> rail_hit);

    p_gain_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gain == '0) |=> (dac_word == '0 && !clip));
endmodule

bind pulse_shaper pulse_shaper_chk #(
    .LANES  (LANES),
    .SEL_W  (SEL_W),
    .SUM_W  (SUM_W),
    .OUT_W  (OUT_W),
    .GAIN_W (GAIN_W),
    .ST_TOT (pshape_pkg::NCOMP * pshape_pkg::ST_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_valid   (hit_valid),
    .hit_lane    (hit_lane),
    .gain        (gain),
    .dac_word    (dac_word),
    .clip        (clip),
    .comp_state  (comp_state),
    .sum_lanes_q (sum_lanes_q)
);

// File: tb/pulse_shaper_test.sv
module pulse_shaper_test;
    localparam int  CLK_PERIOD = 10;
    localparam int  LANES  = 8;
    localparam int  AMP_W  = 16;
    localparam int  OUT_W  = 16;
    localparam int  COEF_W = 18;
    localparam int  SEL_W  = 3;
    localparam int  GAIN_W = 16;
    localparam int  POW_W  = LANES * COEF_W;
    localparam real ONE    = 131072.0;
    localparam int  TOL    = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   hit_valid = 1'b0;
    logic [AMP_W-1:0]       hit_amp = '0;
    logic [SEL_W-1:0]       hit_lane = '0;
    logic [COEF_W-1:0]      w_fast = '0;
    logic [COEF_W-1:0]      w_slow = '0;
    logic [POW_W-1:0]       pow_rise = '0;
    logic [POW_W-1:0]       pow_fast = '0;
    logic [POW_W-1:0]       pow_slow = '0;
    logic [GAIN_W-1:0]      gain = '0;
    logic [LANES*OUT_W-1:0] dac_word;
    logic                   clip;

    pulse_shaper uut (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_amp(hit_amp),
        .hit_lane(hit_lane), .w_fast(w_fast), .w_slow(w_slow),
        .pow_rise(pow_rise), .pow_fast(pow_fast), .pow_slow(pow_slow),
        .gain(gain), .dac_word(dac_word), .clip(clip)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    real a_r, a_f, a_s, wf_r, ws_r;
    real yr = 0.0, yf = 0.0, ys = 0.0;
    real cur_sum [LANES];
    real prev_sum[LANES];
    bit  cur_ok = 0;
    bit  prev_ok = 0;

    // Stimulus table: valid, amplitude, lane, gain, requirement number.
    typedef struct packed {
        logic        v;
        logic [15:0] amp;
        logic [2:0]  lane;
        logic [15:0] g;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 16'd2000, 3'd0, 16'd256, 4'd4},
        '{1'b0, 16'd0,    3'd0, 16'd256, 4'd4},
        '{1'b0, 16'd0,    3'd0, 16'd256, 4'd8},
        '{1'b1, 16'd1200, 3'd3, 16'd256, 4'd4},
        '{1'b1, 16'd800,  3'd7, 16'd256, 4'd8},
        '{1'b1, 16'd1600, 3'd1, 16'd384, 4'd8},
        '{1'b0, 16'd3000, 3'd2, 16'd256, 4'd5},
        '{1'b0, 16'd0,    3'd0, 16'd512, 4'd7},
        '{1'b1, 16'd400,  3'd6, 16'd128, 4'd8},
        '{1'b0, 16'd0,    3'd0, 16'd256, 4'd4},
        '{1'b0, 16'd0,    3'd0, 16'd300, 4'd7},
        '{1'b1, 16'd2400, 3'd4, 16'd256, 4'd4},
        '{1'b1, 16'd2400, 3'd4, 16'd256, 4'd8},
        '{1'b0, 16'd0,    3'd0, 16'd256, 4'd8},
        '{1'b0, 16'd0,    3'd0, 16'd200, 4'd7},
        '{1'b0, 16'd0,    3'd0, 16'd256, 4'd4}
    };

    function automatic logic [POW_W-1:0] pow_vec(input real a);
        logic [POW_W-1:0] v;
        v = '0;
        for (int m = 1; m <= LANES; m++)
            v[(m-1)*COEF_W +: COEF_W] = COEF_W'(longint'($floor($pow(a, m) * ONE)));
        return v;
    endfunction

    task automatic set_coefs(input real ar, input real af, input real as_, input real wf, input real ws);
        a_r = ar; a_f = af; a_s = as_; wf_r = wf; ws_r = ws;
        pow_rise = pow_vec(ar);
        pow_fast = pow_vec(af);
        pow_slow = pow_vec(as_);
        w_fast = COEF_W'(longint'($floor(wf * ONE)));
        w_slow = COEF_W'(longint'($floor(ws * ONE)));
    endtask

    // Serial sample-by-sample reference of the three recursions.
    task automatic model_step(input bit v, input int amp, input int lane);
        for (int k = 0; k < LANES; k++) begin
            real x, xf, xs;
            x  = (v && k == lane) ? real'(amp) : 0.0;
            xf = $floor(x * wf_r);
            xs = $floor(x * ws_r);
            yf = a_f * yf + xf;
            ys = a_s * ys + xs;
            yr = a_r * yr + (xf + xs);
            cur_sum[k] = yf + ys - yr;
        end
    endtask

    function automatic int lane_val(input int k);
        return int'($signed(dac_word[k*OUT_W +: OUT_W]));
    endfunction

    task automatic compare(input int g, input string tag);
        bit   bad = 0;
        bit   eclip = 0;
        int   bad_k = 0, bad_got = 0, bad_exp = 0;
        for (int k = 0; k < LANES; k++) begin
            real e;
            int  got;
            bit  clamped = 0;
            e = $floor(prev_sum[k] * real'(g) / 256.0);
            if (e > 32767.0)       begin e = 32767.0;  clamped = 1; eclip = 1; end
            else if (e < -32768.0) begin e = -32768.0; clamped = 1; eclip = 1; end
            got = lane_val(k);
            if (!bad && ((clamped && got != int'(e)) ||
                         (!clamped && (real'(got) - e > TOL || e - real'(got) > TOL)))) begin
                bad = 1; bad_k = k; bad_got = got; bad_exp = int'(e);
            end
        end
        checks++;
        if (bad) begin
            failures++;
            $display("FAIL %s lane %0d actual=%0d expected=%0d", tag, bad_k, bad_got, bad_exp);
        end
        checks++;
        if (clip !== eclip) begin
            failures++;
            $display("FAIL %s clip actual=%0b expected=%0b", tag, clip, eclip);
        end
    endtask

    task automatic tick(input bit v, input int amp, input int lane, input int g, input string tag);
        prev_sum = cur_sum;
        prev_ok  = cur_ok;
        hit_valid = v;
        hit_amp   = AMP_W'(amp);
        hit_lane  = SEL_W'(lane);
        gain      = GAIN_W'(g);
        model_step(v, amp, lane);
        cur_ok = 1;
        @(posedge clk);
        @(negedge clk);
        if (prev_ok) compare(g, tag);
    endtask

    task automatic expect_int(input string tag, input int got, input int exp_v);
        checks++;
        if (got != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp_v);
        end
    endtask

    task automatic flush(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 0, 0, 256, "R4 flush");
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        for (int k = 0; k < LANES; k++) begin cur_sum[k] = 0.0; prev_sum[k] = 0.0; end
        set_coefs(0.25, 0.5, 0.875, 0.75, 0.25);
        gain = GAIN_W'(256);

        // R1: outputs quiet during reset, even with a hit on the inputs.
        hit_valid = 1'b1; hit_amp = AMP_W'(5000); hit_lane = '0;
        repeat (3) @(negedge clk);
        expect_int("R1 word", int'(dac_word != '0), 0);
        expect_int("R1 clip", int'(clip), 0);
        hit_valid = 1'b0; hit_amp = '0;
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R5/R7/R8: table walk against the serial model.
        for (int i = 0; i < NVEC; i++)
            tick(VECS[i].v, int'(VECS[i].amp), int'(VECS[i].lane), int'(VECS[i].g),
                 $sformatf("R%0d vec%0d", VECS[i].req, i));
        flush(40);

        // R2 and R3: onset at lane 5 from zero state.
        tick(1'b1, 8000, 5, 256, "R3 hit");
        expect_int("R2 word unchanged after one edge", int'(dac_word != '0), 0);
        tick(1'b0, 0, 0, 256, "R2 follow");
        for (int k = 0; k <= 5; k++) expect_int($sformatf("R3 lane %0d zero", k), lane_val(k), 0);
        expect_int("R3 lane 6 positive", int'(lane_val(6) > 0), 1);
        flush(40);

        // R5: invalid hit leaves outputs at zero.
        tick(1'b0, 40000, 0, 256, "R5 ignored");
        tick(1'b0, 0, 0, 256, "R5 follow");
        expect_int("R5 word zero", int'(dac_word != '0), 0);
        flush(4);

        // R7: zero gain blanks a live pulse.
        tick(1'b1, 3000, 2, 256, "R7 hit");
        tick(1'b0, 0, 0, 0, "R7 gain0");
        expect_int("R7 word zero", int'(dac_word != '0), 0);
        expect_int("R7 clip low", int'(clip), 0);
        flush(40);

        // R6: positive rail.
        tick(1'b1, 60000, 0, 65535, "R6 hit pos");
        tick(1'b0, 0, 0, 65535, "R6 pos");
        expect_int("R6 lane 1 at +rail", lane_val(1), 32767);
        expect_int("R6 clip pos", int'(clip), 1);
        expect_int("R6 lane 0 zero", lane_val(0), 0);
        flush(40);

        // R6: negative rail with a slow rise and quick tails.
        set_coefs(0.875, 0.25, 0.25, 0.75, 0.25);
        tick(1'b1, 60000, 0, 65535, "R6 hit neg");
        tick(1'b0, 0, 0, 65535, "R6 neg");
        expect_int("R6 lane 1 at -rail", lane_val(1), -32768);
        expect_int("R6 clip neg", int'(clip), 1);
        flush(60);
        expect_int("R6 clip clears", int'(clip), 0);

        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end
endmodule